// File: doc/BRIEF.md
# Read-to-acquire ownership semaphore

This block arbitrates one shared resource, such as a steering selector, between two bus agents: typically a host path and an embedded controller. Each agent has its own register port. To take the semaphore an agent simply reads it. A read that returns 1 means the agent now holds it, and a read that returns 0 means another agent holds it. The loser keeps polling until it sees 1 or its own time limit runs out. The holder gives the semaphore back by writing 1 to it.

Read data is combinational. The value returned in a cycle reflects the ownership state at the start of that cycle. Any change of ownership appears on the owner output after the next rising clock edge. When both agents read a free semaphore in the same cycle, a parameter chooses which agent wins.

Top module: `steer_sem`

## Requirements
- R1: After reset the owner output is 2'b00 (free), and both granted outputs are 0 while no read is presented.
- R2: A read by one agent while the semaphore is free returns 1 in read-data bit 0. It pulses that agent's granted output in the same cycle. From the next cycle the owner output shows that agent: 2'b01 for port A, 2'b10 for port B.
- R3: When both agents read a free semaphore in the same cycle with A_WINS=1, port A receives 1 and its grant, port B receives 0, and the owner becomes 2'b01.
- R4: A read by the non-owning agent while the semaphore is held returns 0, raises no grant and leaves the owner unchanged.
- R5: A read by the current owner returns 1, keeps ownership and raises no grant.
- R6: A write by the owner with write-data bit 0 set frees the semaphore, so the owner output is 2'b00 from the next cycle.
- R7: A write with bit 0 set by the agent that does not own the semaphore is ignored. So is any write with bit 0 clear.
- R8: Read-data bits above bit 0 are always 0, and read data is 0 in any cycle without a read on that port.
- R9: If the owner releases while the other agent reads in the same cycle, the reader gets 0 and the semaphore is free in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_rd | input | 1 | Port A read strobe |
| a_wr | input | 1 | Port A write strobe |
| a_wdata | input | DW | Port A write data, bit 0 significant |
| a_rdata | output | DW | Port A read data, bit 0 = acquired/held |
| b_rd | input | 1 | Port B read strobe |
| b_wr | input | 1 | Port B write strobe |
| b_wdata | input | DW | Port B write data, bit 0 significant |
| b_rdata | output | DW | Port B read data, bit 0 = acquired/held |
| owner | output | 2 | 00 free, 01 port A, 10 port B |
| a_granted | output | 1 | Pulse: port A acquired in this cycle |
| b_granted | output | 1 | Pulse: port B acquired in this cycle |

## Verification
The bench targets the simultaneous read of a free semaphore. A design with broken priority would hand both agents a 1, or hand the win to B. It also releases in the same cycle that the other agent reads. A design that looked at the next state there would let the reader slip in and take the semaphore as it is freed. Writes by the non-owner and writes with bit 0 clear are checked against the owner output, because a design that decoded either one would drop ownership from under the holder. Re-reads by the owner are checked for a spurious second grant.

// File: rtl/steer_sem.sv
module steer_sem #(
  parameter int DW = 32,
  parameter bit A_WINS = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_rd,
  input  logic          a_wr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_rd,
  input  logic          b_wr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic [1:0]    owner,
  output logic          a_granted,
  output logic          b_granted
);
  localparam logic [1:0] FREE  = 2'b00;
  localparam logic [1:0] HOLDA = 2'b01;
  localparam logic [1:0] HOLDB = 2'b10;

  logic [1:0] own_q, own_d;
  logic is_free, take_a, take_b, rel_a, rel_b;
  logic wdata_unused;

  assign is_free = (own_q == FREE);
  assign take_a  = is_free && a_rd && (A_WINS || !b_rd);
  assign take_b  = is_free && b_rd && (!A_WINS || !a_rd);
  assign rel_a   = (own_q == HOLDA) && a_wr && a_wdata[0];
  assign rel_b   = (own_q == HOLDB) && b_wr && b_wdata[0];

  always_comb begin
    own_d = own_q;
    if (take_a)             own_d = HOLDA;
    else if (take_b)        own_d = HOLDB;
    else if (rel_a || rel_b) own_d = FREE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) own_q <= FREE;
    else        own_q <= own_d;
  end

  assign a_rdata   = {{(DW-1){1'b0}}, a_rd && (take_a || own_q == HOLDA)};
  assign b_rdata   = {{(DW-1){1'b0}}, b_rd && (take_b || own_q == HOLDB)};
  assign a_granted = take_a;
  assign b_granted = take_b;
  assign owner     = own_q;
  assign wdata_unused = ^{a_wdata[DW-1:1], b_wdata[DW-1:1]};
endmodule

// File: rtl/steer_sem_chk.sv
module steer_sem_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_rd,
  input logic          a_wr,
  input logic [DW-1:0] a_wdata,
  input logic [DW-1:0] a_rdata,
  input logic          b_rd,
  input logic          b_wr,
  input logic [DW-1:0] b_wdata,
  input logic [DW-1:0] b_rdata,
  input logic [1:0]    owner,
  input logic          a_granted,
  input logic          b_granted
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_granted && b_granted)); // R3
  AST_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_granted || b_granted) |-> owner == 2'b00); // R2
  AST_GRANT_A_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    a_granted |=> owner == 2'b01); // R2
  AST_GRANT_B_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    b_granted |=> owner == 2'b10); // R2
  AST_BUSY_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd && owner == 2'b10) |-> a_rdata == '0); // R4
  AST_BUSY_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rd && owner == 2'b01) |-> b_rdata == '0); // R4
  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == 2'b01 && !(a_wr && a_wdata[0])) |=> owner == 2'b01); // R7
  AST_RELEASE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == 2'b01 && a_wr && a_wdata[0]) |=> owner == 2'b00); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rdata[DW-1:1] == '0) && (b_rdata[DW-1:1] == '0)); // R8
  AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_rd |-> a_rdata == '0)); // R8
endmodule

bind steer_sem steer_sem_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_steer_sem.sv
module sim_steer_sem;
  localparam int DW = 32;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_rd = 0, a_wr = 0, b_rd = 0, b_wr = 0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
  logic [1:0] owner;
  logic a_granted, b_granted;
  int total = 0, bad = 0;
  int mown = 0;

  always #(PERIOD/2) clk = ~clk;

  steer_sem #(.DW(DW), .A_WINS(1'b1)) u0 (.*);

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic ar, logic aw, logic [DW-1:0] ad,
                      logic br, logic bw, logic [DW-1:0] bd);
    int era, erb, ega, egb, nxt;
    @(negedge clk);
    a_rd = ar; a_wr = aw; a_wdata = ad;
    b_rd = br; b_wr = bw; b_wdata = bd;
    #1;
    ega = (ar && mown == 0) ? 1 : 0;
    egb = (br && mown == 0 && !ar) ? 1 : 0;
    era = (ar && (mown == 1 || ega == 1)) ? 1 : 0;
    erb = (br && (mown == 2 || egb == 1)) ? 1 : 0;
    chk(tag, "owner", owner, mown);
    chk(tag, "a_rdata", a_rdata, era);
    chk(tag, "b_rdata", b_rdata, erb);
    chk(tag, "a_granted", a_granted, ega);
    chk(tag, "b_granted", b_granted, egb);
    nxt = mown;
    if (ega == 1) nxt = 1;
    else if (egb == 1) nxt = 2;
    else if (mown == 1 && aw && ad[0]) nxt = 0;
    else if (mown == 2 && bw && bd[0]) nxt = 0;
    mown = nxt;
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "owner", owner, 0);
    chk("R1", "grants", {a_granted, b_granted}, 0);
    rst_n = 1'b1;
    step("R1", 0, 0, '0, 0, 0, '0);
    step("R2", 1, 0, '0, 0, 0, '0);
    step("R4", 0, 0, '0, 1, 0, '0);
    step("R5", 1, 0, '0, 0, 0, '0);
    step("R7", 0, 0, '0, 0, 1, 32'hFFFF_FFFF);
    step("R7", 0, 1, 32'hFFFF_FFFE, 0, 0, '0);
    step("R7", 1, 0, '0, 1, 0, '0);
    step("R9", 0, 1, 32'h1, 1, 0, '0);
    step("R9", 0, 0, '0, 0, 0, '0);
    step("R3", 1, 0, '0, 1, 0, '0);
    step("R4", 0, 0, '0, 1, 0, '0);
    step("R6", 0, 1, 32'h1, 0, 0, '0);
    step("R2", 0, 0, '0, 1, 0, '0);
    step("R4", 1, 0, '0, 0, 0, '0);
    step("R7", 0, 1, 32'h1, 0, 0, '0);
    step("R5", 0, 0, '0, 1, 0, '0);
    step("R6", 0, 0, '0, 0, 1, 32'h3);
    step("R8", 0, 0, '0, 0, 0, '0);
    step("R7", 0, 1, 32'h1, 0, 1, 32'h1);
    step("R8", 0, 0, '0, 0, 0, '0);
    for (int i = 0; i < 40; i++)
      step("R2", (i % 3) == 0, (i % 5) == 1, DW'(i), (i % 2) == 0, (i % 7) == 3, DW'(i + 1));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule